// File: doc/BRIEF.md
# Block-Indexed Branch Target Buffer

This block predicts taken branches at the fetch stage. Each set covers one 16-byte aligned fetch block and holds up to four branches. All ways of a set share one block tag, and each way records the branch's byte position inside the block. A fetch lookup returns its answer one cycle later: whether a taken branch lies ahead of the fetch byte, that branch's byte offset and its target, and a byte mask that marks the bytes the front end should consume.

Two update ports keep the table current.

- **Decode port.** It inserts a branch as soon as decode sees it. The new entry is flagged speculative and starts in a weak not-taken state. The same port removes an entry when the byte proved not to be a branch.
- **Retire port.** It trains a 2-bit direction counter on the resolved outcome, refreshes the target on a taken outcome and clears the speculative flag.

If both ports address the same set in one cycle, the retire side wins and the decode request must be presented again.

Top module: `fetch_btb`

## Requirements
- R1: A lookup presented in cycle t gives `rsp_valid`=1 in cycle t+1, and `rsp_valid` is 0 after a cycle with no lookup. The answer reflects the table contents before any write made at the same clock edge.
- R2: Address bits [3:0] are the byte offset, bits [10:4] select one of 128 sets, and the upper 21 bits form the block tag. A way matches only if it is valid, its set's tag equals the address tag and its stored offset equals the address offset.
- R3: Consider the matching-tag valid ways whose counter value is 2 or 3 and whose offset is at or above the fetch offset. The one with the lowest offset sets `rsp_hit`=1 and drives its offset and target. With no such way, `rsp_hit`=0, `rsp_off`=0 and `rsp_target`=0.
- R4: `rsp_live` bit i is 1 exactly when i is at or above the fetch offset and, on a hit, i is at or below the branch offset. On a miss the mask runs from the fetch offset to bit 15.
- R5: A decode insert (`dec_op`=0) writes a valid, speculative entry with counter 01, so the entry does not predict taken. An existing entry with the same offset is overwritten in place. If the set held a different tag, all its ways are invalidated and the set takes the new tag.
- R6: An insert uses the lowest-numbered invalid way. If every way is valid, it uses the pseudo-LRU victim. The victim is way 0 or 1 when tree bit 0 is 0, chosen by tree bit 1. It is way 2 or 3 when tree bit 0 is 1, chosen by tree bit 2.
- R7: A decode removal (`dec_op`=1) invalidates the matching way. If no way matches, it has no effect.
- R8: A retire that matches a way steps its counter toward the outcome, saturating at 0 and 3. It clears the speculative flag and, when taken, replaces the target. A retire that matches no way has no effect.
- R9: `dec_accept` is 0 when `dec_valid` and `ret_valid` are both high and address the same set. In that cycle the decode request changes nothing.
- R10: An insert or a matching retire marks its way as most recently used. Tree bit 0 is set to point away from that way's pair, and that pair's bit is set to point at the other way of the pair.
- R11: After reset, every way is invalid, every pseudo-LRU tree is 0 and `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Fetch lookup request |
| lk_addr | input | 32 | Fetch address; the low 4 bits give the fetch byte |
| rsp_valid | output | 1 | Lookup answer present (one cycle after request) |
| rsp_hit | output | 1 | A taken branch is predicted at or after the fetch byte |
| rsp_off | output | 4 | Byte offset of the predicted branch |
| rsp_target | output | 32 | Predicted target |
| rsp_live | output | 16 | Bytes to consume in the block |
| dec_valid | input | 1 | Decode request |
| dec_op | input | 1 | 0 = insert branch, 1 = remove entry |
| dec_addr | input | 32 | Branch byte address |
| dec_target | input | 32 | Decoded target for an insert |
| dec_accept | output | 1 | Decode request taken this cycle |
| ret_valid | input | 1 | Retire update |
| ret_taken | input | 1 | Resolved direction |
| ret_addr | input | 32 | Retired branch byte address |
| ret_target | input | 32 | Resolved target |

## Verification
On every cycle, assertions check the following:

- the one-cycle answer timing;
- the shape of the live mask around the reported branch;
- zeroed fields on a miss;
- a freshly inserted way holding counter 01 with the speculative flag set;
- the flag cleared after a matching retire;
- a blocked decode leaving its set's valid bits alone.

Way choice under pseudo-LRU, selection of the nearest taken branch among several ways, retagging of a set and saturation of the counter all depend on sequences of operations. Only the bench's directed and random scenarios, compared against its own model, can show those.

// File: rtl/fetch_btb_pkg.sv
package fetch_btb_pkg;

   typedef enum logic {
      DEC_INSERT = 1'b0,
      DEC_REMOVE = 1'b1
   } dec_kind_e;

   localparam logic [1:0] CTR_FRESH = 2'b01;

   function automatic logic [1:0] ctr_step(input logic [1:0] c, input logic taken);
      if (taken) return (c == 2'b11) ? c : c + 2'b01;
      return (c == 2'b00) ? c : c - 2'b01;
   endfunction

endpackage

// File: rtl/btb_plru_victim.sv
module btb_plru_victim #(
   parameter int WAYS = 4,
   localparam int WAY_W = $clog2(WAYS),
   localparam int TREE_W = WAYS - 1
) (
   input  logic [TREE_W-1:0] tree_i,
   output logic [WAY_W-1:0]  victim_o
);
   generate
      if (WAYS == 4) begin : g_tree4
         always_comb begin
            victim_o = tree_i[0] ? {1'b1, tree_i[2]} : {1'b0, tree_i[1]};
         end
      end else if (WAYS == 2) begin : g_pair
         always_comb begin
            victim_o = tree_i;
         end
      end else begin : g_bad
         $error("btb_plru_victim: WAYS must be 2 or 4");
      end
   endgenerate
endmodule

// File: rtl/btb_plru_touch.sv
module btb_plru_touch #(
   parameter int WAYS = 4,
   localparam int WAY_W = $clog2(WAYS),
   localparam int TREE_W = WAYS - 1
) (
   input  logic [TREE_W-1:0] tree_i,
   input  logic [WAY_W-1:0]  used_i,
   output logic [TREE_W-1:0] tree_o
);
   generate
      if (WAYS == 4) begin : g_tree4
         always_comb begin
            tree_o    = tree_i;
            tree_o[0] = ~used_i[1];
            if (used_i[1]) tree_o[2] = ~used_i[0];
            else           tree_o[1] = ~used_i[0];
         end
      end else if (WAYS == 2) begin : g_pair
         always_comb begin
            tree_o = ~used_i;
         end
      end else begin : g_bad
         $error("btb_plru_touch: WAYS must be 2 or 4");
      end
   endgenerate
endmodule

// File: rtl/btb_wayfind.sv
module btb_wayfind #(
   parameter int WAYS  = 4,
   parameter int OFF_W = 4,
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic [WAYS-1:0]            valid_i,
   input  logic [WAYS-1:0][OFF_W-1:0] off_i,
   input  logic                       tag_eq_i,
   input  logic [OFF_W-1:0]           q_off_i,
   output logic                       hit_o,
   output logic [WAY_W-1:0]           hit_way_o,
   output logic                       free_o,
   output logic [WAY_W-1:0]           free_way_o
);
   always_comb begin
      hit_o      = 1'b0;
      hit_way_o  = '0;
      free_o     = 1'b0;
      free_way_o = '0;
      // descending scan: the lowest index found last wins
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (tag_eq_i && valid_i[w] && (off_i[w] == q_off_i)) begin
            hit_o     = 1'b1;
            hit_way_o = WAY_W'(w);
         end
         if (!(tag_eq_i && valid_i[w])) begin
            free_o     = 1'b1;
            free_way_o = WAY_W'(w);
         end
      end
   end
endmodule

// File: rtl/btb_pick.sv
module btb_pick #(
   parameter int WAYS  = 4,
   parameter int OFF_W = 4,
   localparam int WAY_W = $clog2(WAYS),
   localparam int BLK   = 1 << OFF_W
) (
   input  logic [WAYS-1:0]            live_i,
   input  logic [WAYS-1:0]            taken_i,
   input  logic [WAYS-1:0][OFF_W-1:0] off_i,
   input  logic [OFF_W-1:0]           fetch_off_i,
   output logic                       hit_o,
   output logic [WAY_W-1:0]           way_o,
   output logic [OFF_W-1:0]           off_o,
   output logic [BLK-1:0]             mask_o
);
   always_comb begin
      hit_o = 1'b0;
      way_o = '0;
      off_o = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (live_i[w] && taken_i[w] && (off_i[w] >= fetch_off_i) &&
             (!hit_o || (off_i[w] < off_o))) begin
            hit_o = 1'b1;
            way_o = WAY_W'(w);
            off_o = off_i[w];
         end
      end
   end

   generate
      for (genvar i = 0; i < BLK; i++) begin : g_mask
         assign mask_o[i] = (OFF_W'(i) >= fetch_off_i) && (!hit_o || (OFF_W'(i) <= off_o));
      end
   endgenerate
endmodule

// File: rtl/fetch_btb.sv
module fetch_btb
   import fetch_btb_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int SETS   = 128,
   parameter int WAYS   = 4,
   parameter int OFF_W  = 4,
   localparam int BLK   = 1 << OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic [OFF_W-1:0]  rsp_off,
   output logic [ADDR_W-1:0] rsp_target,
   output logic [BLK-1:0]    rsp_live,
   input  logic              dec_valid,
   input  logic              dec_op,
   input  logic [ADDR_W-1:0] dec_addr,
   input  logic [ADDR_W-1:0] dec_target,
   output logic              dec_accept,
   input  logic              ret_valid,
   input  logic              ret_taken,
   input  logic [ADDR_W-1:0] ret_addr,
   input  logic [ADDR_W-1:0] ret_target
);
   localparam int IDX_W  = $clog2(SETS);
   localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
   localparam int WAY_W  = $clog2(WAYS);
   localparam int TREE_W = WAYS - 1;

   generate
      if (SETS != (1 << IDX_W)) begin : g_chk_sets
         $error("fetch_btb: SETS must be a power of two");
      end
      if (TAG_W < 1) begin : g_chk_tag
         $error("fetch_btb: address too narrow for tag");
      end
      if ((WAYS != 2) && (WAYS != 4)) begin : g_chk_ways
         $error("fetch_btb: WAYS must be 2 or 4");
      end
   endgenerate

   // ---------------- storage ----------------
   logic [TAG_W-1:0]               set_tag  [SETS];
   logic [WAYS-1:0]                ent_v    [SETS];
   logic [WAYS-1:0]                ent_spec [SETS];
   logic [WAYS-1:0][1:0]           ent_ctr  [SETS];
   logic [WAYS-1:0][OFF_W-1:0]     ent_off  [SETS];
   logic [WAYS-1:0][ADDR_W-1:0]    ent_tgt  [SETS];
   logic [TREE_W-1:0]              lru_tree [SETS];

   // ---------------- address split ----------------
   logic [IDX_W-1:0] l_set, d_set, r_set;
   logic [TAG_W-1:0] l_tag, d_tag, r_tag;
   logic [OFF_W-1:0] l_off, d_off, r_off;

   assign l_off = lk_addr[OFF_W-1:0];
   assign l_set = lk_addr[OFF_W +: IDX_W];
   assign l_tag = lk_addr[ADDR_W-1 -: TAG_W];
   assign d_off = dec_addr[OFF_W-1:0];
   assign d_set = dec_addr[OFF_W +: IDX_W];
   assign d_tag = dec_addr[ADDR_W-1 -: TAG_W];
   assign r_off = ret_addr[OFF_W-1:0];
   assign r_set = ret_addr[OFF_W +: IDX_W];
   assign r_tag = ret_addr[ADDR_W-1 -: TAG_W];

   // a tag only counts while the set holds at least one valid way
   logic l_teq, d_teq, r_teq;
   assign l_teq = (|ent_v[l_set]) && (set_tag[l_set] == l_tag);
   assign d_teq = (|ent_v[d_set]) && (set_tag[d_set] == d_tag);
   assign r_teq = (|ent_v[r_set]) && (set_tag[r_set] == r_tag);

   // ---------------- lookup path ----------------
   logic [WAYS-1:0] l_live, l_taken;
   always_comb begin
      for (int w = 0; w < WAYS; w++) begin
         l_live[w]  = ent_v[l_set][w] && l_teq;
         l_taken[w] = ent_ctr[l_set][w][1];
      end
   end

   logic             p_hit;
   logic [WAY_W-1:0] p_way;
   logic [OFF_W-1:0] p_off;
   logic [BLK-1:0]   p_mask;

   btb_pick #(.WAYS(WAYS), .OFF_W(OFF_W)) u_pick (
      .live_i      (l_live),
      .taken_i     (l_taken),
      .off_i       (ent_off[l_set]),
      .fetch_off_i (l_off),
      .hit_o       (p_hit),
      .way_o       (p_way),
      .off_o       (p_off),
      .mask_o      (p_mask)
   );

   // ---------------- decode port ----------------
   logic             d_hit, d_free;
   logic [WAY_W-1:0] d_hway, d_fway, d_vict, a_way;
   logic [TREE_W-1:0] d_tree_nx;

   btb_wayfind #(.WAYS(WAYS), .OFF_W(OFF_W)) u_find_dec (
      .valid_i    (ent_v[d_set]),
      .off_i      (ent_off[d_set]),
      .tag_eq_i   (d_teq),
      .q_off_i    (d_off),
      .hit_o      (d_hit),
      .hit_way_o  (d_hway),
      .free_o     (d_free),
      .free_way_o (d_fway)
   );

   btb_plru_victim #(.WAYS(WAYS)) u_vict (
      .tree_i   (lru_tree[d_set]),
      .victim_o (d_vict)
   );

   assign a_way = d_hit ? d_hway : (d_free ? d_fway : d_vict);

   btb_plru_touch #(.WAYS(WAYS)) u_touch_dec (
      .tree_i (lru_tree[d_set]),
      .used_i (a_way),
      .tree_o (d_tree_nx)
   );

   logic ins_go, rem_go;
   assign dec_accept = !(dec_valid && ret_valid && (d_set == r_set));
   assign ins_go = dec_valid && dec_accept && (dec_kind_e'(dec_op) == DEC_INSERT);
   assign rem_go = dec_valid && dec_accept && (dec_kind_e'(dec_op) == DEC_REMOVE) && d_hit;

   // ---------------- retire port ----------------
   logic             r_hit, r_free;
   logic [WAY_W-1:0] r_hway, r_fway;
   logic [TREE_W-1:0] r_tree_nx;

   btb_wayfind #(.WAYS(WAYS), .OFF_W(OFF_W)) u_find_ret (
      .valid_i    (ent_v[r_set]),
      .off_i      (ent_off[r_set]),
      .tag_eq_i   (r_teq),
      .q_off_i    (r_off),
      .hit_o      (r_hit),
      .hit_way_o  (r_hway),
      .free_o     (r_free),
      .free_way_o (r_fway)
   );

   btb_plru_touch #(.WAYS(WAYS)) u_touch_ret (
      .tree_i (lru_tree[r_set]),
      .used_i (r_hway),
      .tree_o (r_tree_nx)
   );

   logic ret_go;
   assign ret_go = ret_valid && r_hit;

   // ---------------- state with reset ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            ent_v[s]    <= '0;
            lru_tree[s] <= '0;
         end
         rsp_valid  <= 1'b0;
         rsp_hit    <= 1'b0;
         rsp_off    <= '0;
         rsp_target <= '0;
         rsp_live   <= '0;
      end else begin
         if (ins_go) begin
            if (d_teq) ent_v[d_set][a_way] <= 1'b1;
            else       ent_v[d_set]        <= WAYS'(1) << a_way;
            lru_tree[d_set] <= d_tree_nx;
         end
         if (rem_go) ent_v[d_set][d_hway] <= 1'b0;
         if (ret_go) lru_tree[r_set] <= r_tree_nx;

         rsp_valid  <= lk_valid;
         rsp_hit    <= lk_valid && p_hit;
         rsp_off    <= (lk_valid && p_hit) ? p_off : '0;
         rsp_target <= (lk_valid && p_hit) ? ent_tgt[l_set][p_way] : '0;
         rsp_live   <= lk_valid ? p_mask : '0;
      end
   end

   // ---------------- payload state ----------------
   always_ff @(posedge clk) begin
      if (ins_go) begin
         if (!d_teq) set_tag[d_set] <= d_tag;
         ent_ctr[d_set][a_way]  <= CTR_FRESH;
         ent_spec[d_set][a_way] <= 1'b1;
         ent_off[d_set][a_way]  <= d_off;
         ent_tgt[d_set][a_way]  <= dec_target;
      end
      if (ret_go) begin
         ent_ctr[r_set][r_hway]  <= ctr_step(ent_ctr[r_set][r_hway], ret_taken);
         ent_spec[r_set][r_hway] <= 1'b0;
         if (ret_taken) ent_tgt[r_set][r_hway] <= ret_target;
      end
   end

   // ---------------- assertions ----------------
   // R1
   rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> rsp_valid);
   // R1
   rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> (!rsp_valid && !rsp_hit));
   // R3
   miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_hit) |-> (rsp_off == '0 && rsp_target == '0));
   // R4
   live_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> (rsp_live[rsp_off] && (((rsp_live >> rsp_off) >> 1) == '0)));
   // R5
   fresh_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ins_go |=> (ent_ctr[$past(d_set)][$past(a_way)] == CTR_FRESH &&
                  ent_spec[$past(d_set)][$past(a_way)] && ent_v[$past(d_set)][$past(a_way)]));
   // R8
   retire_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ret_go |=> !ent_spec[$past(r_set)][$past(r_hway)]);
   // R9
   blocked_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && !dec_accept) |=> (ent_v[$past(d_set)] == $past(ent_v[d_set])));
   // R2
   hit_not_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      r_hit |-> !(r_free && (r_fway == r_hway)));

endmodule

// File: tb/fetch_btb_tb_top.sv
module fetch_btb_tb_top;
   localparam int AW = 32, SETS = 128, WAYS = 4, BLK = 16;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n;
   logic lk_valid, dec_valid, dec_op, ret_valid, ret_taken;
   logic [AW-1:0] lk_addr, dec_addr, dec_target, ret_addr, ret_target;
   logic rsp_valid, rsp_hit, dec_accept;
   logic [3:0] rsp_off;
   logic [AW-1:0] rsp_target;
   logic [BLK-1:0] rsp_live;

   int checks = 0, failures = 0;
   bit done = 1'b0;

   fetch_btb dut_i (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_addr(lk_addr),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_off(rsp_off),
      .rsp_target(rsp_target), .rsp_live(rsp_live),
      .dec_valid(dec_valid), .dec_op(dec_op), .dec_addr(dec_addr),
      .dec_target(dec_target), .dec_accept(dec_accept),
      .ret_valid(ret_valid), .ret_taken(ret_taken),
      .ret_addr(ret_addr), .ret_target(ret_target)
   );

   // ---------------- reference model ----------------
   bit [20:0] m_tag [SETS];
   bit        m_v   [SETS][WAYS];
   bit [1:0]  m_c   [SETS][WAYS];
   bit [3:0]  m_o   [SETS][WAYS];
   bit [31:0] m_t   [SETS][WAYS];
   bit [2:0]  m_p   [SETS];

   function automatic int f_set(input logic [31:0] a); return int'(a[10:4]); endfunction
   function automatic logic [31:0] mk(input int tg, input int s, input int o);
      return {tg[20:0], s[6:0], o[3:0]};
   endfunction

   function automatic bit m_teq(input int s, input bit [20:0] tg);
      bit any = 0;
      for (int w = 0; w < WAYS; w++) any |= m_v[s][w];
      return any && (m_tag[s] == tg);
   endfunction

   function automatic int m_match(input logic [31:0] a);
      int s = f_set(a);
      if (!m_teq(s, a[31:11])) return -1;
      for (int w = 0; w < WAYS; w++) if (m_v[s][w] && m_o[s][w] == a[3:0]) return w;
      return -1;
   endfunction

   function automatic int lru_victim(input bit [2:0] p);
      return p[0] ? (p[2] ? 3 : 2) : (p[1] ? 1 : 0);
   endfunction

   function automatic bit [2:0] lru_touch(input bit [2:0] p, input int w);
      bit [2:0] n = p;
      n[0] = (w < 2);
      if (w >= 2) n[2] = (w == 2); else n[1] = (w == 0);
      return n;
   endfunction

   function automatic void m_insert(input logic [31:0] a, input logic [31:0] t);
      int s = f_set(a);
      int w = m_match(a);
      if (!m_teq(s, a[31:11])) begin
         for (int k = 0; k < WAYS; k++) m_v[s][k] = 0;
         m_tag[s] = a[31:11];
      end
      if (w < 0) for (int k = WAYS - 1; k >= 0; k--) if (!m_v[s][k]) w = k;
      if (w < 0) w = lru_victim(m_p[s]);
      m_v[s][w] = 1; m_c[s][w] = 2'b01; m_o[s][w] = a[3:0]; m_t[s][w] = t;
      m_p[s] = lru_touch(m_p[s], w);
   endfunction

   function automatic void m_remove(input logic [31:0] a);
      int w = m_match(a);
      if (w >= 0) m_v[f_set(a)][w] = 0;
   endfunction

   function automatic void m_retire(input logic [31:0] a, input bit tk, input logic [31:0] t);
      int s = f_set(a);
      int w = m_match(a);
      if (w < 0) return;
      if (tk) begin if (m_c[s][w] != 3) m_c[s][w]++; m_t[s][w] = t; end
      else if (m_c[s][w] != 0) m_c[s][w]--;
      m_p[s] = lru_touch(m_p[s], w);
   endfunction

   // ---------------- check helpers ----------------
   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // one cycle: called at a falling edge, returns at the next falling edge
   task automatic step(input string tag, input bit lv, input logic [31:0] la,
                       input bit dv, input bit dop, input logic [31:0] da, input logic [31:0] dt,
                       input bit rv, input bit rt, input logic [31:0] ra, input logic [31:0] rtg);
      bit acc, e_hit;
      logic [3:0] e_off;
      logic [31:0] e_tgt;
      logic [15:0] e_mask;
      int s, bo, bw;
      lk_valid = lv; lk_addr = la;
      dec_valid = dv; dec_op = dop; dec_addr = da; dec_target = dt;
      ret_valid = rv; ret_taken = rt; ret_addr = ra; ret_target = rtg;
      #1;
      acc = !(dv && rv && f_set(da) == f_set(ra));
      if (dv) chk("R9", "dec_accept", dec_accept, acc);
      // expected lookup from pre-write model state
      s = f_set(la); bo = -1; bw = 0;
      if (m_teq(s, la[31:11]))
         for (int w = 0; w < WAYS; w++)
            if (m_v[s][w] && m_c[s][w][1] && m_o[s][w] >= la[3:0] && (bo < 0 || m_o[s][w] < bo)) begin
               bo = m_o[s][w]; bw = w;
            end
      e_hit = (bo >= 0);
      e_off = e_hit ? 4'(bo) : 4'd0;
      e_tgt = e_hit ? m_t[s][bw] : 32'd0;
      for (int i = 0; i < BLK; i++) e_mask[i] = (i >= la[3:0]) && (!e_hit || i <= bo);
      if (rv) m_retire(ra, rt, rtg);
      if (dv && acc) begin
         if (dop == 1'b0) m_insert(da, dt); else m_remove(da);
      end
      @(posedge clk);
      @(negedge clk);
      chk("R1", "rsp_valid", rsp_valid, lv);
      if (lv) begin
         chk(tag, "rsp_hit", rsp_hit, e_hit);
         chk(tag, "rsp_off", rsp_off, e_off);
         chk(tag, "rsp_target", rsp_target, e_tgt);
         chk("R4", "rsp_live", rsp_live, e_mask);
      end
   endtask

   task automatic look(input string tag, input logic [31:0] a);
      step(tag, 1, a, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask
   task automatic ins(input logic [31:0] a, input logic [31:0] t);
      step("R5", 0, 0, 1, 0, a, t, 0, 0, 0, 0);
   endtask
   task automatic rem(input logic [31:0] a);
      step("R7", 0, 0, 1, 1, a, 0, 0, 0, 0, 0);
   endtask
   task automatic ret(input logic [31:0] a, input bit tk, input logic [31:0] t);
      step("R8", 0, 0, 0, 0, 0, 0, 1, tk, a, t);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++; checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      void'($urandom(32'd24681));
      rst_n = 1'b0;
      lk_valid = 0; lk_addr = 0; dec_valid = 0; dec_op = 0; dec_addr = 0; dec_target = 0;
      ret_valid = 0; ret_taken = 0; ret_addr = 0; ret_target = 0;
      for (int s = 0; s < SETS; s++) begin
         m_p[s] = 0; m_tag[s] = 0;
         for (int w = 0; w < WAYS; w++) begin m_v[s][w] = 0; m_c[s][w] = 0; m_o[s][w] = 0; m_t[s][w] = 0; end
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R11", "rsp_valid in reset", rsp_valid, 1'b0);
      rst_n = 1'b1;

      // R11: empty table misses, mask from byte 3 upward
      look("R11", mk(3, 5, 3));
      chk("R11", "empty mask literal", rsp_live, 16'hfff8);

      // R5: fresh insert does not predict taken
      ins(mk(3, 5, 6), 32'h1000_0600);
      look("R5", mk(3, 5, 0));
      chk("R5", "fresh entry hit literal", rsp_hit, 1'b0);

      // R8: one taken retire makes it predict taken with new target
      ret(mk(3, 5, 6), 1, 32'h2000_0600);
      look("R8", mk(3, 5, 0));
      chk("R8", "trained hit literal", rsp_hit, 1'b1);
      chk("R8", "trained target literal", rsp_target, 32'h2000_0600);
      chk("R4", "mask to branch literal", rsp_live, 16'h007f);
      look("R3", mk(3, 5, 7));
      chk("R3", "past branch literal", rsp_hit, 1'b0);

      // R3: nearest taken branch at or after fetch byte
      ins(mk(3, 5, 2), 32'h3000_0002);
      ins(mk(3, 5, 10), 32'h3000_000a);
      ins(mk(3, 5, 13), 32'h3000_000d);
      ret(mk(3, 5, 10), 1, 32'h4000_000a);
      ret(mk(3, 5, 10), 1, 32'h4000_000a);
      look("R3", mk(3, 5, 3));
      chk("R3", "nearest offset literal", rsp_off, 4'd6);
      look("R3", mk(3, 5, 7));
      chk("R3", "second offset literal", rsp_off, 4'd10);

      // R6/R10: full set, pseudo-LRU picks way 0 (offset 6)
      step("R6", 0, 0, 1, 0, mk(3, 5, 9), 32'h5000_0009, 0, 0, 0, 0);
      look("R10", mk(3, 5, 0));
      chk("R6", "victim evicted literal", rsp_off, 4'd10);

      // R7: remove, and remove of absent byte
      rem(mk(3, 5, 10));
      look("R7", mk(3, 5, 0));
      chk("R7", "after remove literal", rsp_hit, 1'b0);
      rem(mk(3, 5, 1));
      look("R7", mk(3, 5, 0));

      // R9: same-set conflict, retire wins
      step("R9", 1, mk(3, 5, 0), 1, 0, mk(3, 5, 1), 32'h6000_0001, 1, 1, mk(3, 5, 13), 32'h6000_000d);
      step("R9", 1, mk(3, 5, 0), 1, 0, mk(3, 5, 1), 32'h6000_0001, 1, 1, mk(3, 6, 13), 32'h6000_000d);
      look("R9", mk(3, 5, 0));
      chk("R9", "retire applied literal", rsp_off, 4'd13);

      // R5: retag drops old block
      ins(mk(4, 5, 3), 32'h7000_0003);
      look("R5", mk(3, 5, 0));
      chk("R5", "old tag gone literal", rsp_hit, 1'b0);
      ret(mk(4, 5, 3), 1, 32'h7100_0003);
      look("R2", mk(4, 5, 0));

      // R8: retire to absent entry ignored, saturation
      ret(mk(3, 5, 13), 0, 0);
      look("R8", mk(4, 5, 0));
      ret(mk(4, 5, 3), 1, 32'h7200_0003);
      ret(mk(4, 5, 3), 1, 32'h7200_0003);
      ret(mk(4, 5, 3), 0, 0);
      look("R8", mk(4, 5, 0));
      chk("R8", "saturated stays taken literal", rsp_hit, 1'b1);
      ret(mk(4, 5, 3), 0, 0);
      ret(mk(4, 5, 3), 0, 0);
      look("R8", mk(4, 5, 0));
      chk("R8", "trained down literal", rsp_hit, 1'b0);

      // constrained random traffic on a small address footprint
      for (int n = 0; n < 3000; n++) begin
         bit lv, dv, dop, rv, rt;
         logic [31:0] la, da, ra;
         lv  = ($urandom % 10) < 7;
         dv  = ($urandom % 10) < 4;
         dop = ($urandom % 4) == 0;
         rv  = ($urandom % 10) < 5;
         rt  = ($urandom % 10) < 6;
         la  = mk($urandom % 2, $urandom % 2, $urandom % 16);
         da  = mk($urandom % 2, $urandom % 2, ($urandom % 8) * 2);
         ra  = mk($urandom % 2, $urandom % 2, ($urandom % 8) * 2);
         step("R3", lv, la, dv, dop, da, $urandom, rv, rt, ra, $urandom);
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule